// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the bookkeeping side of a write-back, write-allocate cache: per-line tags, valid bits, dirty bits and replacement ages. It stores no data. A client presents one 64-bit byte address and a read/write flag per cycle on a valid/ready handshake. One cycle after a request is accepted, the block reports whether it hit. It also reports whether the line it displaced must be written back, and the tag of that line.

The geometry is fixed at elaboration by three base-2 logarithms: total capacity, block size and ways per set. Setting the way exponent to zero gives a direct-mapped cache. Setting it equal to the capacity exponent minus the block exponent gives one fully associative set. A mode input chooses the victim policy, either least-recently-used or first-in-first-out. Seven running counters cover accesses, reads, writes, read misses, write misses, total misses and write-backs.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address is split as follows. Bits [BLK_LOG2-1:0] are the byte offset and play no part in lookup. The next CAP_LOG2-BLK_LOG2-WAY_LOG2 bits select the set. All remaining upper bits form the tag. Two addresses that differ only in offset hit the same line, and a difference in any tag or index bit makes a separate line.
- R2: `req_ready` is high from the second clock edge after reset is released. A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. `rsp_valid` is high in exactly the cycle after each accepted request and low otherwise.
- R3: Reset clears every valid bit, every dirty bit and every counter. After reset, the first access to any address misses.
- R4: A request hits when a valid way of the selected set holds the request's tag. `rsp_hit` is 1 on a hit and 0 on a miss.
- R5: On a miss, the block fills the lowest-numbered invalid way of the set. While a set still has an invalid way, a miss evicts nothing and reports no write-back.
- R6: Any write, hit or miss, leaves its line dirty, and a read hit leaves the dirty bit unchanged. A line filled by a read miss is clean. When a valid dirty line is evicted, `rsp_wb` is 1 and `rsp_victim_tag` carries that line's tag. Otherwise `rsp_wb` is 0 and `rsp_victim_tag` is zero.
- R7: With `policy_sel` = 0 (LRU), the victim is the way in the set that was least recently hit or filled.
- R8: With `policy_sel` = 1 (FIFO), the victim is the way filled longest ago, and hits do not change the order. `policy_sel` is held constant between resets.
- R9: The counters count accepted requests. `cnt_access` counts all of them, `cnt_read` and `cnt_write` split them by kind, `cnt_read_miss` and `cnt_write_miss` count misses of each kind, `cnt_miss` counts all misses, and `cnt_wb` counts responses with `rsp_wb` = 1. Each counter is updated in the same edge as the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W (64) | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| policy_sel | input | 1 | 0 = LRU, 1 = FIFO |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_wb | output | 1 | Dirty victim must be written back |
| rsp_victim_tag | output | TAG_W (56) | Tag of the dirty victim, zero otherwise |
| cnt_access | output | CNT_W | Accepted requests |
| cnt_read | output | CNT_W | Accepted reads |
| cnt_write | output | CNT_W | Accepted writes |
| cnt_read_miss | output | CNT_W | Read misses |
| cnt_write_miss | output | CNT_W | Write misses |
| cnt_miss | output | CNT_W | All misses |
| cnt_wb | output | CNT_W | Write-backs |

## Verification
The hardest situation to reach from the ports is one where LRU and FIFO pick different victims. That needs a set that is completely full, followed by a hit to its oldest line and then a new tag. Only the identity of the line written back, and whether a later re-read of the old line hits, reveals which order the block kept. The stimulus builds this directly: it fills one set with four tags and re-touches the first. It then issues a conflicting tag under each mode and re-reads the displaced candidates. Dirty lines are used so that the victim tag appears on the port. Long random runs then confine addresses to two sets and eight tags, which keeps every set under constant eviction pressure.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_FIFO = 1'b1
  } policy_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/ctc_addr_split.sv
module ctc_addr_split #(
  parameter int ADDR_W   = 64,
  parameter int BLK_LOG2 = 4,
  parameter int IDX_W    = 4,
  parameter int IDX_B    = 4,
  parameter int TAG_W    = 56
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_B-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  generate
    if (IDX_W > 0) begin : g_indexed
      assign idx = addr[BLK_LOG2 +: IDX_W];
    end else begin : g_single_set
      assign idx = '0;
    end
  endgenerate

  assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/ctc_way_lookup.sv
module ctc_way_lookup #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int AGE_W = 2,
  parameter int TAG_W = 56
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0][AGE_W-1:0] set_age,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           free_way,
  output logic                       all_valid,
  output logic [WAY_W-1:0]           old_way
);

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hit_vec[gw] = set_valid[gw] && (set_tags[gw] == req_tag);
    end
  endgenerate

  assign hit       = |hit_vec;
  assign all_valid = &set_valid;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) free_way = WAY_W'(w);
    end
  end

  always_comb begin
    logic [AGE_W-1:0] best_age;
    best_age = '0;
    old_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_age[w] > best_age) begin
        best_age = set_age[w];
        old_way  = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/ctc_age_update.sv
module ctc_age_update #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] age_cur,
  input  logic                       touch_en,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][AGE_W-1:0] age_nxt
);

  logic [AGE_W-1:0] pivot;
  assign pivot = age_cur[touch_way];

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      always_comb begin
        if (!touch_en) begin
          age_nxt[gw] = age_cur[gw];
        end else if (WAY_W'(gw) == touch_way) begin
          age_nxt[gw] = '0;
        end else if (age_cur[gw] < pivot) begin
          age_nxt[gw] = age_cur[gw] + 1'b1;
        end else begin
          age_nxt[gw] = age_cur[gw];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ctc_stats.sv
module ctc_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             is_write,
  input  logic             is_miss,
  input  logic             is_wb,
  output logic [CNT_W-1:0] n_access,
  output logic [CNT_W-1:0] n_read,
  output logic [CNT_W-1:0] n_write,
  output logic [CNT_W-1:0] n_read_miss,
  output logic [CNT_W-1:0] n_write_miss,
  output logic [CNT_W-1:0] n_miss,
  output logic [CNT_W-1:0] n_wb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_access     <= '0;
      n_read       <= '0;
      n_write      <= '0;
      n_read_miss  <= '0;
      n_write_miss <= '0;
      n_miss       <= '0;
      n_wb         <= '0;
    end else if (acc) begin
      n_access <= n_access + 1'b1;
      if (is_write) begin
        n_write <= n_write + 1'b1;
        if (is_miss) n_write_miss <= n_write_miss + 1'b1;
      end else begin
        n_read <= n_read + 1'b1;
        if (is_miss) n_read_miss <= n_read_miss + 1'b1;
      end
      if (is_miss) n_miss <= n_miss + 1'b1;
      if (is_wb)   n_wb   <= n_wb + 1'b1;
    end
  end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import ctc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int CAP_LOG2 = 10,
  parameter int BLK_LOG2 = 4,
  parameter int WAY_LOG2 = 2,
  parameter int CNT_W    = 32,
  localparam int IDX_W   = CAP_LOG2 - BLK_LOG2 - WAY_LOG2,
  localparam int IDX_B   = at_least_one(IDX_W),
  localparam int SETS    = 1 << IDX_W,
  localparam int WAYS    = 1 << WAY_LOG2,
  localparam int WAY_W   = at_least_one(WAY_LOG2),
  localparam int AGE_W   = WAY_W,
  localparam int TAG_W   = ADDR_W - BLK_LOG2 - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              policy_sel,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_wb,
  output logic [TAG_W-1:0]  rsp_victim_tag,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_read,
  output logic [CNT_W-1:0]  cnt_write,
  output logic [CNT_W-1:0]  cnt_read_miss,
  output logic [CNT_W-1:0]  cnt_write_miss,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_wb
);

  // Metadata arrays, one entry per set
  logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
  logic [WAYS-1:0]            vld_q   [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_q   [SETS];

  logic [IDX_B-1:0]           idx;
  logic [TAG_W-1:0]           tag;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0]            set_dirty;
  logic [WAYS-1:0][AGE_W-1:0] set_age;
  logic [WAYS-1:0][AGE_W-1:0] age_nxt;

  logic             hit;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] touch_way;
  logic             all_valid;
  logic             acc;
  logic             evict;
  logic             need_wb;
  logic             touch_en;
  policy_e          policy;

  assign policy = policy_e'(policy_sel);
  assign acc    = req_valid && req_ready;

  ctc_addr_split #(
    .ADDR_W  (ADDR_W),
    .BLK_LOG2(BLK_LOG2),
    .IDX_W   (IDX_W),
    .IDX_B   (IDX_B),
    .TAG_W   (TAG_W)
  ) u_split (
    .addr(req_addr),
    .idx (idx),
    .tag (tag)
  );

  assign set_tags  = tag_mem[idx];
  assign set_valid = vld_q[idx];
  assign set_dirty = dirty_q[idx];
  assign set_age   = age_q[idx];

  ctc_way_lookup #(
    .WAYS (WAYS),
    .WAY_W(WAY_W),
    .AGE_W(AGE_W),
    .TAG_W(TAG_W)
  ) u_lookup (
    .set_tags (set_tags),
    .set_valid(set_valid),
    .set_age  (set_age),
    .req_tag  (tag),
    .hit      (hit),
    .hit_vec  (hit_vec),
    .hit_way  (hit_way),
    .free_way (free_way),
    .all_valid(all_valid),
    .old_way  (old_way)
  );

  assign fill_way  = all_valid ? old_way : free_way;
  assign evict     = !hit && all_valid;
  assign need_wb   = evict && set_dirty[fill_way];
  assign touch_way = hit ? hit_way : fill_way;
  assign touch_en  = acc && (!hit || (policy == POL_LRU));

  ctc_age_update #(
    .WAYS (WAYS),
    .WAY_W(WAY_W),
    .AGE_W(AGE_W)
  ) u_age (
    .age_cur  (set_age),
    .touch_en (touch_en),
    .touch_way(touch_way),
    .age_nxt  (age_nxt)
  );

  // Tag store: no reset, single write port
  always_ff @(posedge clk) begin
    if (acc && !hit) tag_mem[idx][fill_way] <= tag;
  end

  // State bits and ages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else if (acc) begin
      if (!hit) begin
        vld_q[idx][fill_way]   <= 1'b1;
        dirty_q[idx][fill_way] <= req_write;
      end else if (req_write) begin
        dirty_q[idx][hit_way]  <= 1'b1;
      end
      age_q[idx] <= age_nxt;
    end
  end

  // Handshake and response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready      <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_wb         <= 1'b0;
      rsp_victim_tag <= '0;
    end else begin
      req_ready      <= 1'b1;
      rsp_valid      <= acc;
      rsp_hit        <= acc && hit;
      rsp_wb         <= acc && need_wb;
      rsp_victim_tag <= (acc && need_wb) ? set_tags[fill_way] : '0;
    end
  end

  ctc_stats #(
    .CNT_W(CNT_W)
  ) u_stats (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .is_write    (req_write),
    .is_miss     (!hit),
    .is_wb       (need_wb),
    .n_access    (cnt_access),
    .n_read      (cnt_read),
    .n_write     (cnt_write),
    .n_read_miss (cnt_read_miss),
    .n_write_miss(cnt_write_miss),
    .n_miss      (cnt_miss),
    .n_wb        (cnt_wb)
  );

endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 56,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_wb,
  input logic [TAG_W-1:0] rsp_victim_tag,
  input logic [WAYS-1:0]  hit_vec,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_read,
  input logic [CNT_W-1:0] cnt_write,
  input logic [CNT_W-1:0] cnt_read_miss,
  input logic [CNT_W-1:0] cnt_write_miss,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_wb
);

  assert_ready_up_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> req_ready);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_counters_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_access == '0 && cnt_miss == '0 && cnt_wb == '0));

  assert_single_way_hit_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_wb_only_on_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wb) |-> !rsp_hit);

  assert_clean_victim_tag_R6: assert property (@(posedge clk) disable iff (rst)
    !rsp_wb |-> (rsp_victim_tag == '0));

  assert_access_split_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_access == CNT_W'(cnt_read + cnt_write));

  assert_miss_split_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_miss == CNT_W'(cnt_read_miss + cnt_write_miss));

  assert_access_step_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cnt_access == CNT_W'($past(cnt_access) + 1'b1));

  assert_wb_step_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wb) |-> cnt_wb == CNT_W'($past(cnt_wb) + 1'b1));

endmodule

bind cache_tag_ctrl ctc_checker #(
  .WAYS (WAYS),
  .TAG_W(TAG_W),
  .CNT_W(CNT_W)
) u_ctc_checker (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_wb        (rsp_wb),
  .rsp_victim_tag(rsp_victim_tag),
  .hit_vec       (hit_vec),
  .cnt_access    (cnt_access),
  .cnt_read      (cnt_read),
  .cnt_write     (cnt_write),
  .cnt_read_miss (cnt_read_miss),
  .cnt_write_miss(cnt_write_miss),
  .cnt_miss      (cnt_miss),
  .cnt_wb        (cnt_wb)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;

  localparam int PERIOD = 10;
  localparam int NSETS  = 16;
  localparam int NWAYS  = 4;
  localparam int TW     = 56;
  localparam int CW     = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [63:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic          policy_sel = 1'b0;
  logic          rsp_valid, rsp_hit, rsp_wb;
  logic [TW-1:0] rsp_victim_tag;
  logic [CW-1:0] cnt_access, cnt_read, cnt_write, cnt_read_miss;
  logic [CW-1:0] cnt_write_miss, cnt_miss, cnt_wb;

  always #(PERIOD/2) clk = ~clk;

  cache_tag_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .policy_sel(policy_sel),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_wb(rsp_wb),
    .rsp_victim_tag(rsp_victim_tag), .cnt_access(cnt_access),
    .cnt_read(cnt_read), .cnt_write(cnt_write), .cnt_read_miss(cnt_read_miss),
    .cnt_write_miss(cnt_write_miss), .cnt_miss(cnt_miss), .cnt_wb(cnt_wb)
  );

  typedef struct {
    bit          hit;
    bit          wb;
    logic [63:0] vtag;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // Reference model, timestamp based
  logic [TW-1:0] m_tag  [NSETS][NWAYS];
  bit            m_v    [NSETS][NWAYS];
  bit            m_d    [NSETS][NWAYS];
  int            m_fill [NSETS][NWAYS];
  int            m_use  [NSETS][NWAYS];
  int            stamp;
  int            e_acc, e_rd, e_wr, e_rm, e_wm, e_miss, e_wb;

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_fill[s][w] = 0; m_use[s][w] = 0;
      end
    stamp = 0;
    e_acc = 0; e_rd = 0; e_wr = 0; e_rm = 0; e_wm = 0; e_miss = 0; e_wb = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [TW-1:0] t, input int s, input int off);
    return {t, 4'(s), 4'(off)};
  endfunction

  task automatic model_access(input logic [63:0] a, input bit wr, output exp_t e);
    int s;
    logic [TW-1:0] t;
    int hw, vw;
    s  = int'(a[7:4]);
    t  = a[63:8];
    hw = -1;
    stamp++;
    for (int w = 0; w < NWAYS; w++) if (m_v[s][w] && m_tag[s][w] == t) hw = w;
    e.hit = (hw >= 0); e.wb = 0; e.vtag = '0;
    e_acc++;
    if (wr) e_wr++; else e_rd++;
    if (hw >= 0) begin
      if (policy_sel == 1'b0) m_use[s][hw] = stamp;
      if (wr) m_d[s][hw] = 1;
    end else begin
      e_miss++;
      if (wr) e_wm++; else e_rm++;
      vw = -1;
      for (int w = NWAYS - 1; w >= 0; w--) if (!m_v[s][w]) vw = w;
      if (vw < 0) begin
        vw = 0;
        for (int w = 1; w < NWAYS; w++) begin
          if (policy_sel == 1'b0) begin
            if (m_use[s][w] < m_use[s][vw]) vw = w;
          end else begin
            if (m_fill[s][w] < m_fill[s][vw]) vw = w;
          end
        end
        if (m_d[s][vw]) begin
          e.wb = 1; e.vtag = {8'h0, m_tag[s][vw]}; e_wb++;
        end
      end
      m_tag[s][vw] = t; m_v[s][vw] = 1; m_d[s][vw] = wr;
      m_fill[s][vw] = stamp; m_use[s][vw] = stamp;
    end
  endtask

  // Driver: one accepted request per call
  task automatic access(input logic [63:0] a, input bit wr, input string req);
    exp_t e;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "req_ready before request", 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    e.req = req;
    model_access(a, wr, e);
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares each response after the edge that produced it
  always begin
    @(posedge clk);
    #1;
    if (!rst && !done) begin
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_valid === 1'b1, "R2", "rsp_valid after accept", 64'(rsp_valid), 64'h1);
        chk(rsp_hit === e.hit, e.req, "rsp_hit", 64'(rsp_hit), 64'(e.hit));
        chk(rsp_wb === e.wb, e.req, "rsp_wb", 64'(rsp_wb), 64'(e.wb));
        chk({8'h0, rsp_victim_tag} === e.vtag, e.req, "rsp_victim_tag",
            {8'h0, rsp_victim_tag}, e.vtag);
      end else if (rsp_valid !== 1'b0) begin
        chk(1'b0, "R2", "rsp_valid without request", 64'(rsp_valid), 64'h0);
      end
    end
  end

  task automatic check_counters(input string req);
    chk(cnt_access     == CW'(e_acc),  req, "cnt_access",     64'(cnt_access),     64'(e_acc));
    chk(cnt_read       == CW'(e_rd),   req, "cnt_read",       64'(cnt_read),       64'(e_rd));
    chk(cnt_write      == CW'(e_wr),   req, "cnt_write",      64'(cnt_write),      64'(e_wr));
    chk(cnt_read_miss  == CW'(e_rm),   req, "cnt_read_miss",  64'(cnt_read_miss),  64'(e_rm));
    chk(cnt_write_miss == CW'(e_wm),   req, "cnt_write_miss", 64'(cnt_write_miss), 64'(e_wm));
    chk(cnt_miss       == CW'(e_miss), req, "cnt_miss",       64'(cnt_miss),       64'(e_miss));
    chk(cnt_wb         == CW'(e_wb),   req, "cnt_wb",         64'(cnt_wb),         64'(e_wb));
  endtask

  task automatic do_reset(input bit pol);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    policy_sel = pol;
    model_reset();
    idle(3);
    rst = 1'b0;
    idle(2);
    chk(rsp_valid === 1'b0, "R3", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check_counters("R3");
  endtask

  task automatic random_run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom;
      if (r[3:0] == 4'd0) idle(1);
      access(mk(TW'(r[6:4]), r[7], r[11:8]), r[12], req);
    end
    idle(2);
  endtask

  initial begin
    model_reset();
    do_reset(1'b0);

    // R1: offset ignored, tag and index bits significant
    access(mk(TW'(1), 3, 0), 1'b0, "R3");
    access(mk(TW'(1), 3, 15), 1'b0, "R1");
    access(mk(TW'(1) | (TW'(1) << 55), 3, 0), 1'b0, "R1");
    access(mk(TW'(1), 2, 7), 1'b0, "R1");
    access(mk(TW'(1), 3, 9), 1'b0, "R4");

    // R5 then R7: fill set 5 with dirty lines, re-touch the first
    for (int k = 0; k < 4; k++) access(mk(TW'(10 + k), 5, k), 1'b1, "R5");
    for (int k = 0; k < 4; k++) access(mk(TW'(10 + k), 5, 0), 1'b0, "R5");
    access(mk(TW'(10), 5, 0), 1'b0, "R4");
    access(mk(TW'(14), 5, 0), 1'b0, "R7");
    access(mk(TW'(10), 5, 0), 1'b0, "R7");
    access(mk(TW'(11), 5, 0), 1'b0, "R7");

    // R6: clean eviction, dirty bit kept across read hit
    for (int k = 0; k < 5; k++) access(mk(TW'(20 + k), 6, 0), 1'b0, "R6");
    access(mk(TW'(30), 7, 0), 1'b1, "R6");
    access(mk(TW'(30), 7, 4), 1'b0, "R6");
    for (int k = 1; k < 5; k++) access(mk(TW'(30 + k), 7, 0), 1'b0, "R6");
    idle(2);
    check_counters("R9");

    // R3: reset forgets contents
    do_reset(1'b1);
    access(mk(TW'(10), 5, 0), 1'b0, "R3");

    // R8: FIFO order ignores hits
    for (int k = 1; k < 4; k++) access(mk(TW'(10 + k), 5, 0), 1'b0, "R8");
    access(mk(TW'(10), 5, 0), 1'b0, "R8");
    access(mk(TW'(14), 5, 0), 1'b0, "R8");
    access(mk(TW'(10), 5, 0), 1'b0, "R8");
    for (int k = 0; k < 4; k++) access(mk(TW'(40 + k), 8, 0), 1'b1, "R8");
    access(mk(TW'(40), 8, 0), 1'b0, "R8");
    access(mk(TW'(44), 8, 0), 1'b1, "R8");
    access(mk(TW'(40), 8, 0), 1'b0, "R8");
    idle(2);
    check_counters("R9");

    random_run(600, "R8");
    check_counters("R9");

    do_reset(1'b0);
    random_run(600, "R7");
    check_counters("R9");

    idle(2);
    chk(exp_q.size() == 0, "R2", "responses outstanding", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule